// File: doc/BRIEF.md
# Serial Coefficient and Register Loader

This block is the configuration front end of a multi-tap image filter. Host software or a sequencer feeds it a stream of 12-bit words on a single bus, together with an active-low load strobe and a pause input. Each transaction opens with an address word. The upper three bits of that word choose a target space: the coefficient banks, or the configuration, select, round or limit register files. The lower nine bits give a location within that space. The data words that follow the address are turned into write pulses, with address and data, for the matching storage.

How many data words a transaction holds depends on its target. A coefficient transaction carries one word for each of the eight banks. Configuration and select transactions carry one word. Round and limit transactions carry four byte-wide words, which are packed lowest byte first into one 32-bit value and written in a single pulse. A fresh falling edge on the strobe always restarts the loader, even in the middle of a transaction. Holding pause high freezes the loader without losing any state.

Top module: `cfg_word_loader`

## Requirements
- R1: The loader decodes the address word by its bits 11..9. The codes are 000 for the coefficient banks, 001 for configuration, 011 for select, 101 for round and 111 for limit. Bits 8..0 give the location. For a register space, bits 3..0 of the location appear on `reg_addr`.
- R2: An address word is taken on the clock edge where `ld_n` is sampled low and its previous unpaused sample was high.
- R3: A coefficient address is followed by eight data words. Data word k (0..7) is written to bank k at the location, so `coef_we` carries a single set bit k with `coef_addr` equal to the location and `coef_data` equal to the word. The pulse appears in the cycle after the word is sampled. At most one write enable of the whole block is high in any cycle.
- R4: A configuration or select address is followed by one data word. That word is written in full through `cfg_we` or `sel_we`, with `reg_data` equal to the word.
- R5: A round or limit address is followed by four data words. Bits 7..0 of each word are payload, the first word being the least significant byte. Bits 11..8 are ignored. One pulse on `rnd_we` or `lim_we` carries the whole 32-bit value on `wide_data`, and only after the fourth word.
- R6: While `pause` is high, the loader consumes no word and detects no strobe edge. A write pulse never follows a paused cycle. A falling edge that occurs during a pause is acted on in the first unpaused cycle.
- R7: An address word with code 010, 100 or 110, or a register-space location of 16 or more, produces no write for the words that follow it.
- R8: A new falling edge of `ld_n` during a transaction ends that transaction, and the word on that cycle is taken as a new address. A round or limit value that is partly assembled is never written.
- R9: Once a transaction has taken all its words, further words produce no write until the next falling edge. This holds whether `ld_n` stays low or returns high.
- R10: During and after reset, all write enables are low and the loader is idle, with the strobe history treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Load strobe; a high-to-low transition starts a transaction |
| pause | input | 1 | Freezes the loader while high |
| din | input | 12 | Address or data word |
| coef_we | output | 8 | Per-bank coefficient write enables |
| coef_addr | output | 9 | Coefficient location |
| coef_data | output | 12 | Coefficient value |
| cfg_we | output | 1 | Configuration register write |
| sel_we | output | 1 | Select register write |
| reg_addr | output | 4 | Register index for all four register files |
| reg_data | output | 12 | Configuration or select value |
| rnd_we | output | 1 | Round register write |
| lim_we | output | 1 | Limit register write |
| wide_data | output | 32 | Assembled round or limit value |

## Verification
The hardest case to reach from the ports is a strobe edge that lands mid-transaction while a round or limit value is half-built. The bench reaches it by raising `ld_n` on an ordinary data byte. That byte is still consumed, which leaves a valid high history. `ld_n` then drops with a configuration address two bytes into a limit load, and the bench confirms that the limit entry stays untouched. A second hard case is an edge that arrives during a pause. Here the bench lowers `ld_n` while `pause` is high and changes the bus several times. It then releases the pause and checks that exactly the address on the bus at release is used. Later, while a round load is under way, it pauses again with stray data on the bus.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   typedef enum logic [2:0] {
      SP_NONE = 3'd0,
      SP_COEF = 3'd1,
      SP_CFG  = 3'd2,
      SP_SEL  = 3'd3,
      SP_RND  = 3'd4,
      SP_LIM  = 3'd5
   } space_t;

   localparam logic [2:0] CODE_COEF = 3'b000;
   localparam logic [2:0] CODE_CFG  = 3'b001;
   localparam logic [2:0] CODE_SEL  = 3'b011;
   localparam logic [2:0] CODE_RND  = 3'b101;
   localparam logic [2:0] CODE_LIM  = 3'b111;

endpackage

// File: rtl/cfgld_space_decode.sv
module cfgld_space_decode
   import cfgld_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int LOC_W      = 9,
   parameter int REG_DEPTH  = 16,
   parameter int N_BANKS    = 8,
   parameter int WIDE_BYTES = 4,
   parameter int CNT_W      = 4
) (
   input  logic [WORD_W-1:0] word,
   output space_t            space,
   output logic [LOC_W-1:0]  loc,
   output logic [CNT_W-1:0]  count
);
   localparam int CODE_W = WORD_W - LOC_W;

   generate
      if (CODE_W != 3) begin : g_bad_code
         $error("space code field must be 3 bits wide");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              reg_ok;

   always_comb begin
      code   = word[WORD_W-1:LOC_W];
      loc    = word[LOC_W-1:0];
      reg_ok = (int'(loc) < REG_DEPTH);
      space  = SP_NONE;
      count  = '0;
      unique case (code)
         CODE_COEF: begin space = SP_COEF; count = CNT_W'(N_BANKS); end
         CODE_CFG:  if (reg_ok) begin space = SP_CFG; count = CNT_W'(1); end
         CODE_SEL:  if (reg_ok) begin space = SP_SEL; count = CNT_W'(1); end
         CODE_RND:  if (reg_ok) begin space = SP_RND; count = CNT_W'(WIDE_BYTES); end
         CODE_LIM:  if (reg_ok) begin space = SP_LIM; count = CNT_W'(WIDE_BYTES); end
         default: ;
      endcase
   end
endmodule

// File: rtl/cfgld_sequencer.sv
module cfgld_sequencer
   import cfgld_pkg::*;
#(
   parameter int LOC_W = 9,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_n,
   input  logic             pause,
   input  space_t           dec_space,
   input  logic [LOC_W-1:0] dec_loc,
   input  logic [CNT_W-1:0] dec_count,
   output logic             start,
   output logic             take,
   output logic             last,
   output space_t           space_q,
   output logic [LOC_W-1:0] loc_q,
   output logic [CNT_W-1:0] idx_q
);
   logic             ld_prev_q;
   logic             active_q;
   logic [CNT_W-1:0] total_q;

   assign start = !pause && ld_prev_q && !ld_n;
   assign take  = !pause && active_q && !start;
   assign last  = (idx_q == total_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_prev_q <= 1'b1;
         active_q  <= 1'b0;
         space_q   <= SP_NONE;
         loc_q     <= '0;
         total_q   <= '0;
         idx_q     <= '0;
      end else if (!pause) begin
         ld_prev_q <= ld_n;
         if (start) begin
            active_q <= (dec_space != SP_NONE);
            space_q  <= dec_space;
            loc_q    <= dec_loc;
            total_q  <= dec_count;
            idx_q    <= '0;
         end else if (take) begin
            idx_q <= idx_q + CNT_W'(1);
            if (last) active_q <= 1'b0;
         end
      end
   end

   // R6
   pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> $stable(idx_q) && $stable(active_q) && $stable(ld_prev_q));

   // R3
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> idx_q == $past(idx_q) + CNT_W'(1));
endmodule

// File: rtl/cfgld_byte_packer.sv
module cfgld_byte_packer #(
   parameter int BYTE_W     = 8,
   parameter int WIDE_BYTES = 4,
   parameter int CNT_W      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         take,
   input  logic                         commit,
   input  logic [CNT_W-1:0]             idx,
   input  logic [BYTE_W-1:0]            byte_in,
   output logic [WIDE_BYTES*BYTE_W-1:0] wide_out
);
   generate
      if (WIDE_BYTES < 2) begin : g_bad_bytes
         $error("a wide value needs at least two bytes");
      end
   endgenerate

   logic [WIDE_BYTES-1:0] filled_q;

   genvar k;
   generate
      for (k = 0; k < WIDE_BYTES; k++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;
         logic              hit;
         assign hit = (idx == CNT_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lane_q <= '0;
            else if (take && hit) lane_q <= byte_in;
         end
         assign wide_out[k*BYTE_W +: BYTE_W] = hit ? byte_in : lane_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filled_q <= '0;
      else if (start) filled_q <= '0;
      else if (take && int'(idx) < WIDE_BYTES) filled_q[idx] <= 1'b1;
   end

   // R5
   full_before_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> &filled_q[WIDE_BYTES-2:0]);
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
   import cfgld_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int LOC_W      = 9,
   parameter int N_BANKS    = 8,
   parameter int REG_DEPTH  = 16,
   parameter int BYTE_W     = 8,
   parameter int WIDE_BYTES = 4,
   localparam int WIDE_W    = BYTE_W * WIDE_BYTES,
   localparam int RADDR_W   = $clog2(REG_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_n,
   input  logic               pause,
   input  logic [WORD_W-1:0]  din,
   output logic [N_BANKS-1:0] coef_we,
   output logic [LOC_W-1:0]   coef_addr,
   output logic [WORD_W-1:0]  coef_data,
   output logic               cfg_we,
   output logic               sel_we,
   output logic [RADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0]  reg_data,
   output logic               rnd_we,
   output logic               lim_we,
   output logic [WIDE_W-1:0]  wide_data
);
   localparam int CNT_W = $clog2(N_BANKS + 1);

   generate
      if (BYTE_W > WORD_W) begin : g_bad_byte
         $error("payload byte wider than the input word");
      end
      if (N_BANKS < WIDE_BYTES) begin : g_bad_cnt
         $error("word counter too narrow for the wide registers");
      end
      if (REG_DEPTH > (1 << LOC_W) || REG_DEPTH < 2) begin : g_bad_depth
         $error("register depth does not fit the location field");
      end
   endgenerate

   space_t             dec_space, space_q;
   logic [LOC_W-1:0]   dec_loc, loc_q;
   logic [CNT_W-1:0]   dec_count, idx_q;
   logic               start, take, last, commit;
   logic [WIDE_W-1:0]  wide_next;

   cfgld_space_decode #(
      .WORD_W(WORD_W), .LOC_W(LOC_W), .REG_DEPTH(REG_DEPTH),
      .N_BANKS(N_BANKS), .WIDE_BYTES(WIDE_BYTES), .CNT_W(CNT_W)
   ) u_dec (
      .word(din), .space(dec_space), .loc(dec_loc), .count(dec_count)
   );

   cfgld_sequencer #(.LOC_W(LOC_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause),
      .dec_space(dec_space), .dec_loc(dec_loc), .dec_count(dec_count),
      .start(start), .take(take), .last(last),
      .space_q(space_q), .loc_q(loc_q), .idx_q(idx_q)
   );

   assign commit = take && last && (space_q == SP_RND || space_q == SP_LIM);

   cfgld_byte_packer #(.BYTE_W(BYTE_W), .WIDE_BYTES(WIDE_BYTES), .CNT_W(CNT_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .start(start), .take(take), .commit(commit),
      .idx(idx_q), .byte_in(din[BYTE_W-1:0]), .wide_out(wide_next)
   );

   genvar b;
   generate
      for (b = 0; b < N_BANKS; b++) begin : g_bank_we
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) coef_we[b] <= 1'b0;
            else        coef_we[b] <= take && space_q == SP_COEF && idx_q == CNT_W'(b);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_we    <= 1'b0;
         sel_we    <= 1'b0;
         rnd_we    <= 1'b0;
         lim_we    <= 1'b0;
         coef_addr <= '0;
         coef_data <= '0;
         reg_addr  <= '0;
         reg_data  <= '0;
         wide_data <= '0;
      end else begin
         cfg_we <= take && space_q == SP_CFG;
         sel_we <= take && space_q == SP_SEL;
         rnd_we <= commit && space_q == SP_RND;
         lim_we <= commit && space_q == SP_LIM;
         if (take) begin
            coef_addr <= loc_q;
            coef_data <= din;
            reg_addr  <= loc_q[RADDR_W-1:0];
            reg_data  <= din;
         end
         if (commit) wide_data <= wide_next;
      end
   end

   logic any_we;
   assign any_we = (|coef_we) | cfg_we | sel_we | rnd_we | lim_we;

   // R3
   we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({coef_we, cfg_we, sel_we, rnd_we, lim_we}));

   // R6
   pause_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> !any_we);

   // R8
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !any_we);
endmodule

// File: tb/cfg_word_loader_tb.sv
module cfg_word_loader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_n = 1'b1;
   logic        pause = 1'b0;
   logic [11:0] din = '0;
   logic [7:0]  coef_we;
   logic [8:0]  coef_addr;
   logic [11:0] coef_data;
   logic        cfg_we, sel_we, rnd_we, lim_we;
   logic [3:0]  reg_addr;
   logic [11:0] reg_data;
   logic [31:0] wide_data;

   always #4 clk = ~clk;

   cfg_word_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .pause(pause), .din(din),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .cfg_we(cfg_we), .sel_we(sel_we), .reg_addr(reg_addr), .reg_data(reg_data),
      .rnd_we(rnd_we), .lim_we(lim_we), .wide_data(wide_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [11:0] coef_m [8][512];
   logic [11:0] cfg_m [16];
   logic [11:0] sel_m [16];
   logic [31:0] rnd_m [16];
   logic [31:0] lim_m [16];
   int wcount = 0;

   initial begin
      for (int k = 0; k < 8; k++) for (int a = 0; a < 512; a++) coef_m[k][a] = '0;
      for (int r = 0; r < 16; r++) begin
         cfg_m[r] = '0; sel_m[r] = '0; rnd_m[r] = '0; lim_m[r] = '0;
      end
   end

   always @(negedge clk) begin
      for (int k = 0; k < 8; k++) if (coef_we[k] === 1'b1) begin
         coef_m[k][coef_addr] = coef_data; wcount++;
      end
      if (cfg_we === 1'b1) begin cfg_m[reg_addr] = reg_data;  wcount++; end
      if (sel_we === 1'b1) begin sel_m[reg_addr] = reg_data;  wcount++; end
      if (rnd_we === 1'b1) begin rnd_m[reg_addr] = wide_data; wcount++; end
      if (lim_we === 1'b1) begin lim_m[reg_addr] = wide_data; wcount++; end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   localparam int NV = 7;
   localparam logic [11:0] V_ADDR [NV] = '{12'h00F, 12'h203, 12'h60F, 12'hA0C, 12'hE0A, 12'h400, 12'hE10};
   localparam int V_LEN [NV] = '{8, 1, 1, 4, 4, 4, 4};
   localparam int V_WR  [NV] = '{8, 1, 1, 1, 1, 0, 0};
   localparam logic [11:0] V_DATA [NV][8] = '{
      '{12'h210, 12'h543, 12'hC76, 12'h9E3, 12'h701, 12'h832, 12'hF20, 12'h143},
      '{12'hA5C, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
      '{12'h3B1, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
      '{12'h012, 12'hF34, 12'h056, 12'h0F8, 12'h0, 12'h0, 12'h0, 12'h0},
      '{12'h0EF, 12'h0CD, 12'h0AB, 12'h089, 12'h0, 12'h0, 12'h0, 12'h0},
      '{12'h111, 12'h222, 12'h333, 12'h444, 12'h0, 12'h0, 12'h0, 12'h0},
      '{12'h011, 12'h022, 12'h033, 12'h044, 12'h0, 12'h0, 12'h0, 12'h0}
   };

   task automatic send(input logic [11:0] a, input logic [11:0] d [8], input int n);
      @(negedge clk); ld_n = 1'b0; din = a;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); din = d[i];
         if (i == n - 1) ld_n = 1'b1;
      end
      @(negedge clk); ld_n = 1'b1; din = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int w0;
      logic [31:0] expv;
      logic [3:0]  loc;
      repeat (3) @(negedge clk);
      // R10: enables low while in reset
      chk({coef_we, cfg_we, sel_we, rnd_we, lim_we} == '0, "R10 in reset",
          {20'h0, coef_we, cfg_we, sel_we, rnd_we, lim_we}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({coef_we, cfg_we, sel_we, rnd_we, lim_we} == '0 && wcount == 0, "R10 after reset",
          wcount, 32'h0);

      for (int v = 0; v < NV; v++) begin
         w0 = wcount;
         send(V_ADDR[v], V_DATA[v], V_LEN[v]);
         chk(wcount - w0 == V_WR[v], (V_WR[v] == 0) ? "R7 write count" : "R1 R2 write count",
             wcount - w0, V_WR[v]);
         loc = V_ADDR[v][3:0];
         case (V_ADDR[v][11:9])
            3'b000: for (int k = 0; k < 8; k++)
               chk(coef_m[k][V_ADDR[v][8:0]] == V_DATA[v][k], "R3 coefficient bank",
                   coef_m[k][V_ADDR[v][8:0]], V_DATA[v][k]);
            3'b001: chk(cfg_m[loc] == V_DATA[v][0], "R4 config", cfg_m[loc], V_DATA[v][0]);
            3'b011: chk(sel_m[loc] == V_DATA[v][0], "R4 select", sel_m[loc], V_DATA[v][0]);
            3'b101, 3'b111: if (V_WR[v] != 0) begin
               expv = {V_DATA[v][3][7:0], V_DATA[v][2][7:0], V_DATA[v][1][7:0], V_DATA[v][0][7:0]};
               if (V_ADDR[v][11:9] == 3'b101)
                  chk(rnd_m[loc] == expv, "R5 round", rnd_m[loc], expv);
               else
                  chk(lim_m[loc] == expv, "R5 limit", lim_m[loc], expv);
            end
            default: ;
         endcase
      end

      // R9: words with ld_n high after a finished transaction
      w0 = wcount;
      for (int i = 0; i < 4; i++) begin @(negedge clk); din = 12'h2A0 + 12'(i); end
      @(negedge clk); @(negedge clk);
      chk(wcount == w0, "R9 idle words ld_n high", wcount - w0, 0);

      // R9: ld_n held low past the end of a config transaction
      w0 = wcount;
      @(negedge clk); ld_n = 1'b0; din = 12'h20A;
      @(negedge clk); din = 12'h0AA;
      @(negedge clk); din = 12'h0BB;
      @(negedge clk); din = 12'h0CC;
      @(negedge clk); ld_n = 1'b1; din = '0;
      @(negedge clk); @(negedge clk);
      chk(wcount - w0 == 1, "R9 ld_n low count", wcount - w0, 1);
      chk(cfg_m[10] == 12'h0AA, "R9 ld_n low value", cfg_m[10], 12'h0AA);

      // R8: abort a limit load after two bytes with a config address
      w0 = wcount;
      @(negedge clk); ld_n = 1'b0; din = 12'hE03;
      @(negedge clk); din = 12'h011;
      @(negedge clk); din = 12'h022; ld_n = 1'b1;
      @(negedge clk); din = 12'h205; ld_n = 1'b0;
      @(negedge clk); din = 12'h111; ld_n = 1'b1;
      @(negedge clk); din = 12'h033;
      @(negedge clk); din = '0;
      @(negedge clk);
      chk(wcount - w0 == 1, "R8 abort count", wcount - w0, 1);
      chk(cfg_m[5] == 12'h111, "R8 new address", cfg_m[5], 12'h111);
      chk(lim_m[3] == 32'h0, "R8 partial discarded", lim_m[3], 32'h0);

      // R6: falling edge during pause, then pause mid round load
      w0 = wcount;
      @(negedge clk); pause = 1'b1; ld_n = 1'b0; din = 12'h3FF;
      @(negedge clk); din = 12'h1FF;
      @(negedge clk); din = 12'hA05;
      @(negedge clk); pause = 1'b0;
      @(negedge clk); din = 12'h001;
      @(negedge clk); din = 12'h002;
      @(negedge clk); pause = 1'b1; din = 12'h0FF;
      @(negedge clk); din = 12'h0EE;
      @(negedge clk); din = 12'h0DD;
      chk(wcount == w0, "R6 no write while paused", wcount - w0, 0);
      @(negedge clk); pause = 1'b0; din = 12'h003;
      @(negedge clk); din = 12'h004; ld_n = 1'b1;
      @(negedge clk); din = '0;
      @(negedge clk);
      chk(wcount - w0 == 1, "R6 pause count", wcount - w0, 1);
      chk(rnd_m[5] == 32'h04030201, "R6 pause value", rnd_m[5], 32'h04030201);
      chk(cfg_m[15] == 12'h0 && sel_m[15] == 12'h3B1, "R6 stray words unused",
          {cfg_m[15], sel_m[15]}, {12'h0, 12'h3B1});

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule